// File: doc/BRIEF.md
# 16-bit Timer/Counter with Forced Compare

This block is a 16-bit up-counter with three output-compare channels (A, B, C). A CPU reaches it over an 8-bit register bus. The counter advances on each pulse of a timer-clock enable, `tick`. On a tick, any channel whose compare register equals the counter raises a sticky match flag and updates an internal compare-output bit. The channel's 2-bit action field sets how that bit changes.

Every 16-bit register is moved as two bytes through one shared temporary high-byte latch, so each 16-bit transfer is atomic. A mode field selects one of three counting schemes:
- free-running wrap;
- clear-on-compare, with channel A as TOP;
- one of two waveform modes.

The waveform modes count like free-running. In them the force-compare strobes are ignored. A CPU write to the counter suppresses the compare logic on the next tick for all channels. This prevents a spurious match when software reloads the counter.

The register map uses byte addresses on `bus_addr`:

| Address | Contents |
|---|---|
| 0 / 1 | Counter, low / high byte |
| 2 / 3 | Channel A compare, low / high byte |
| 4 / 5 | Channel B compare, low / high byte |
| 6 / 7 | Channel C compare, low / high byte |
| 8 | Mode |
| 9 | Action fields |
| 10 | Force strobes |
| 11 | Flags |
| 12 | Compare-output bits |

Top module: `tmr16_fc`

## Requirements
- R1: After reset every readable location (addresses 0 to 12) reads 0.
- R2: Reading a low byte (even address 0..6) returns that register's low byte and copies its high byte into the shared temporary latch. Reading any high byte (odd address 1..7) returns the latch, so a high-byte read after a low-byte read returns the value the high byte had at the low-byte read.
- R3: Writing any high byte (odd address 1..7) loads the shared latch. Writing a low byte (even address 0..6) loads the whole 16-bit register with {latch, written byte} in one cycle, even if the latch was loaded through another register's high-byte address.
- R4: With mode (address 8, bits 1:0) equal to 0, 2 or 3, each tick adds 1 to the counter, and 0xFFFF wraps to 0x0000.
- R5: With mode 1, a tick on which the counter equals the channel A compare register loads 0 instead of incrementing. The match condition for this reload applies even when matches are suppressed.
- R6: A tick on which channel i's compare register equals the counter sets flag i (address 11: bit 0 = A, bit 1 = B, bit 2 = C). Writing 1 to a flag bit clears it. A match in the same cycle wins over the clear.
- R7: On a match, channel i's output bit (address 12, bit i) follows its action field (address 9, bits 2i+1:2i): 00 keeps the bit, 01 inverts it, 10 clears it, 11 sets it.
- R8: A write to the counter low byte takes precedence over a tick in the same cycle. It blocks every channel's match on the next tick: no flag is set and no output bit changes. The counter still counts on that tick.
- R9: Writing address 10 with bit 7 (A), bit 6 (B) or bit 5 (C) set applies that channel's action to its output bit, but only in modes 0 and 1. A forced compare never sets a flag and never reloads or alters the counter, including in mode 1 on channel A. In modes 2 and 3 it has no effect.
- R10: Address 10 always reads 0, including its low five bits.
- R11: When a genuine match and a forced compare hit the same channel in the same cycle, the action is applied once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer-clock enable; one count per high cycle |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address (0 to 12) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |

## Verification
The bench attacks the shared latch with the following sequences:
- It reads a low byte, lets the counter run, then reads the high byte. A design that read the live high byte would return a byte that had already moved on.
- It writes a high byte through one register's address and commits it through another's. A design with per-register latches would commit a stale byte.

It reloads the counter exactly onto a compare value, sometimes in the same cycle as a tick. A design without suppression would raise a flag, and one that let the tick win would lose the written value.

Forced compares are issued in each mode and against a mode-1 TOP. A design that set a flag, cleared the counter, or honoured the strobe in a waveform mode would show a wrong flag, counter or output bit. Forced and genuine matches are also made to coincide under a toggle action. Double application would leave the output bit unchanged.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

  // Counting scheme selected by the mode register.
  typedef enum logic [1:0] {
    MODE_FREE    = 2'd0,
    MODE_CLR_TOP = 2'd1,
    MODE_WAVE_A  = 2'd2,
    MODE_WAVE_B  = 2'd3
  } tmr_mode_e;

  // Waveform modes ignore force strobes.
  function automatic logic is_wave(tmr_mode_e m);
    return m[1];
  endfunction

  // Compare-output action: keep, invert, clear, set.
  function automatic logic oc_apply(logic [1:0] act, logic cur);
    logic r;
    case (act)
      2'b00:   r = cur;
      2'b01:   r = ~cur;
      2'b10:   r = 1'b0;
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int NCH    = 3,
  parameter int ADDR_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_sel,
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [BUS_W-1:0]              bus_wdata,
  output logic [BUS_W-1:0]              bus_rdata,
  input  logic [2*BUS_W-1:0]            cnt,
  input  logic [NCH-1:0]                flag,
  input  logic [NCH-1:0]                oc,
  output logic                          cnt_wr,
  output logic [2*BUS_W-1:0]            cnt_wr_val,
  output logic [NCH-1:0][2*BUS_W-1:0]   cmp,
  output tmr_mode_e                     mode,
  output logic [NCH-1:0][1:0]           com,
  output logic [NCH-1:0]                force_hit,
  output logic [NCH-1:0]                flag_clr
);
  localparam int CW = 2 * BUS_W;
  localparam int NW = NCH + 1;  // 16-bit words: counter + compares
  localparam logic [ADDR_W-1:0] A_CNT_LO = '0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(2 * NW);
  localparam logic [ADDR_W-1:0] A_COM    = ADDR_W'(2 * NW + 1);
  localparam logic [ADDR_W-1:0] A_FORCE  = ADDR_W'(2 * NW + 2);
  localparam logic [ADDR_W-1:0] A_FLAG   = ADDR_W'(2 * NW + 3);
  localparam logic [ADDR_W-1:0] A_OCB    = ADDR_W'(2 * NW + 4);

  logic                 wr, rd, in_words, hi_sel;
  logic [ADDR_W-2:0]    word_idx;
  logic [CW-1:0]        sel_word;
  logic [BUS_W-1:0]     temp_q;

  assign wr       = bus_sel & bus_we;
  assign rd       = bus_sel & ~bus_we;
  assign in_words = bus_addr < A_MODE;
  assign hi_sel   = bus_addr[0];
  assign word_idx = bus_addr[ADDR_W-1:1];

  // Word addressed by the current byte address.
  always_comb begin
    sel_word = cnt;
    for (int c = 0; c < NCH; c++)
      if (int'(word_idx) == c + 1) sel_word = cmp[c];
  end

  assign cnt_wr     = wr && bus_addr == A_CNT_LO;
  assign cnt_wr_val = {temp_q, bus_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      temp_q <= '0;
      cmp    <= '0;
      mode   <= MODE_FREE;
      com    <= '0;
    end else begin
      if (wr && in_words && hi_sel)
        temp_q <= bus_wdata;
      else if (rd && in_words && !hi_sel)
        temp_q <= sel_word[CW-1:BUS_W];
      for (int c = 0; c < NCH; c++)
        if (wr && in_words && !hi_sel && int'(word_idx) == c + 1)
          cmp[c] <= {temp_q, bus_wdata};
      if (wr && bus_addr == A_MODE) mode <= tmr_mode_e'(bus_wdata[1:0]);
      if (wr && bus_addr == A_COM)  com  <= bus_wdata[2*NCH-1:0];
    end
  end

  // Force strobes live only for the write cycle.
  generate
    for (genvar g = 0; g < NCH; g++) begin : g_strobe
      assign force_hit[g] = wr && bus_addr == A_FORCE &&
                            bus_wdata[BUS_W-1-g] && !is_wave(mode);
      assign flag_clr[g]  = wr && bus_addr == A_FLAG && bus_wdata[g];
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (in_words) bus_rdata = hi_sel ? temp_q : sel_word[BUS_W-1:0];
    else if (bus_addr == A_MODE) bus_rdata = BUS_W'(mode);
    else if (bus_addr == A_COM)  bus_rdata = BUS_W'(com);
    else if (bus_addr == A_FLAG) bus_rdata = BUS_W'(flag);
    else if (bus_addr == A_OCB)  bus_rdata = BUS_W'(oc);
  end

  // R2: high-byte read returns the high byte seen at the preceding low-byte read
  a_r2_latched_high: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd && bus_addr == A_CNT_LO) && rd && bus_addr == A_CNT_HI
      |-> bus_rdata == $past(cnt[CW-1:BUS_W]));

  // R3: low-byte commit carries the byte written to the high address just before
  a_r3_commit_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr && bus_addr == A_CNT_HI) && wr && bus_addr == A_CNT_LO
      |-> cnt_wr_val == {$past(bus_wdata), bus_wdata});

  // R10: force location reads zero
  a_r10_force_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd && bus_addr == A_FORCE |-> bus_rdata == '0);

endmodule

// File: rtl/tmr_count.sv
`timescale 1ns/1ps
module tmr_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_val,
  input  logic          clr_mode,
  input  logic [CW-1:0] top,
  output logic [CW-1:0] cnt,
  output logic          cmp_eval
);
  logic blk_q;

  function automatic logic [CW-1:0] step(logic [CW-1:0] v, logic reload);
    return reload ? '0 : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      blk_q <= 1'b0;
    end else if (wr_en) begin
      cnt   <= wr_val;
      blk_q <= 1'b1;
    end else if (tick) begin
      cnt   <= step(cnt, clr_mode && cnt == top);
      blk_q <= 1'b0;
    end
  end

  // Compare is sampled on ticks not shadowed by a counter write.
  assign cmp_eval = tick && !wr_en && !blk_q;

  // R8: a counter write loads the value, even alongside a tick
  a_r8_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cnt == $past(wr_val));

  // R4: free-running wrap from all-ones to zero
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_en && !clr_mode && cnt == '1 |=> cnt == '0);

  // R5: clear-on-compare reload at TOP
  a_r5_clear_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_en && clr_mode && cnt == top |=> cnt == '0);

endmodule

// File: rtl/tmr_chan.sv
`timescale 1ns/1ps
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_eval,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cmp,
  input  logic [1:0]    com,
  input  logic          force_hit,
  input  logic          flag_clr,
  output logic          hit,
  output logic          flag,
  output logic          oc
);
  assign hit = cmp_eval && cnt == cmp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      oc   <= 1'b0;
    end else begin
      if (hit) flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      // A genuine match and a strobe in one cycle act only once.
      if (hit || force_hit) oc <= oc_apply(com, oc);
    end
  end

  // R6: genuine match raises the flag
  a_r6_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  // R9: forced compare leaves the flag alone
  a_r9_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    force_hit && !hit && !flag_clr |=> flag == $past(flag));

  // R7: action 00 keeps the output bit
  a_r7_keep_action: assert property (@(posedge clk) disable iff (!rst_n)
    com == 2'b00 |=> oc == $past(oc));

endmodule

// File: rtl/tmr16_fc.sv
`timescale 1ns/1ps
module tmr16_fc
  import tmr_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int NCH    = 3,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata
);
  localparam int CW = 2 * BUS_W;

  logic                      cnt_wr, cmp_eval;
  logic [CW-1:0]             cnt_wr_val, cnt;
  logic [NCH-1:0][CW-1:0]    cmp;
  logic [NCH-1:0][1:0]       com;
  logic [NCH-1:0]            force_hit, flag_clr, hit, flag, oc;
  tmr_mode_e                 mode;

  tmr_regs #(.BUS_W(BUS_W), .NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt), .flag(flag), .oc(oc),
    .cnt_wr(cnt_wr), .cnt_wr_val(cnt_wr_val), .cmp(cmp), .mode(mode),
    .com(com), .force_hit(force_hit), .flag_clr(flag_clr)
  );

  tmr_count #(.CW(CW)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_en(cnt_wr), .wr_val(cnt_wr_val),
    .clr_mode(mode == MODE_CLR_TOP), .top(cmp[0]),
    .cnt(cnt), .cmp_eval(cmp_eval)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      tmr_chan #(.CW(CW)) u_chan (
        .clk(clk), .rst_n(rst_n), .cmp_eval(cmp_eval),
        .cnt(cnt), .cmp(cmp[g]), .com(com[g]),
        .force_hit(force_hit[g]), .flag_clr(flag_clr[g]),
        .hit(hit[g]), .flag(flag[g]), .oc(oc[g])
      );
    end
  endgenerate

  // R8: the cycle after a counter write no channel matches
  a_r8_block_all: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_wr) |-> hit == '0);

  // R9: a force strobe alone never moves the counter
  a_r9_force_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    force_hit != '0 && !tick && !cnt_wr |=> cnt == $past(cnt));

endmodule

// File: tb/tmr16_fc_bench.sv
`timescale 1ns/1ps
module tmr16_fc_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0, tick = 1'b0, bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;

  always #2 clk = ~clk;  // 250 MHz

  tmr16_fc u_tmr16_fc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int n_vec = 0, n_bad = 0;

  // Reference state, built from the requirements.
  logic [15:0] m_cnt;
  logic [15:0] m_cmp [3];
  logic [7:0]  m_tmp;
  logic [1:0]  m_mode;
  logic [5:0]  m_com;
  logic [2:0]  m_flag, m_oc;
  bit          m_blk;

  function automatic logic [15:0] m_word(input int w);
    return (w == 0) ? m_cnt : m_cmp[w-1];
  endfunction

  function automatic logic [7:0] m_read(input logic [3:0] a);
    if (a < 4'd8) return a[0] ? m_tmp : m_word(int'(a[3:1]))[7:0];
    if (a == 4'd8)  return {6'd0, m_mode};
    if (a == 4'd9)  return {2'd0, m_com};
    if (a == 4'd11) return {5'd0, m_flag};
    if (a == 4'd12) return {5'd0, m_oc};
    return 8'h00;  // R10 and unused
  endfunction

  // R7 action table, restated as a lookup.
  function automatic logic act(input logic [1:0] c, input logic b);
    logic [3:0] res;
    res = {1'b1, 1'b0, ~b, b};
    return res[c];
  endfunction

  task automatic step(input bit sel, input bit we, input logic [3:0] a,
                      input logic [7:0] d, input bit tk, input string tag);
    logic [2:0] hit;
    logic [7:0] ntmp;
    bit cw, ev;
    bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = d; tick = tk;
    #1;
    if (sel && !we) begin
      n_vec++;
      if (bus_rdata !== m_read(a)) begin
        n_bad++;
        $display("FAIL %s addr %0d got %h exp %h", tag, a, bus_rdata, m_read(a));
      end
    end
    cw = sel && we && a == 4'd0;
    ev = tk && !cw && !m_blk;
    for (int i = 0; i < 3; i++) hit[i] = ev && (m_cnt == m_cmp[i]);
    ntmp = m_tmp;
    if (sel && we && a < 4'd8 && a[0]) ntmp = d;
    else if (sel && !we && a < 4'd8 && !a[0]) ntmp = m_word(int'(a[3:1]))[15:8];
    for (int i = 0; i < 3; i++) begin
      if (hit[i] || (sel && we && a == 4'd10 && d[7-i] && m_mode < 2'd2))
        m_oc[i] = act(m_com[2*i +: 2], m_oc[i]);
      if (hit[i]) m_flag[i] = 1'b1;
      else if (sel && we && a == 4'd11 && d[i]) m_flag[i] = 1'b0;
    end
    if (cw) begin
      m_cnt = {m_tmp, d}; m_blk = 1'b1;
    end else if (tk) begin
      m_cnt = (m_mode == 2'd1 && m_cnt == m_cmp[0]) ? 16'h0 : m_cnt + 16'h1;
      m_blk = 1'b0;
    end
    if (sel && we && a < 4'd8 && !a[0] && a != 4'd0) m_cmp[int'(a[3:1]) - 1] = {m_tmp, d};
    if (sel && we && a == 4'd8) m_mode = d[1:0];
    if (sel && we && a == 4'd9) m_com = d[5:0];
    m_tmp = ntmp;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    step(1'b1, 1'b0, a, 8'h00, 1'b0, tag);
  endtask
  task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
    step(1'b1, 1'b1, a, d, 1'b0, tag);
  endtask
  task automatic wr16(input logic [3:0] lo, input logic [15:0] v, input string tag);
    wr(lo + 4'd1, v[15:8], tag);
    wr(lo, v[7:0], tag);
  endtask
  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 4'd0, 8'h00, 1'b1, tag);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_cnt = '0; m_tmp = '0; m_mode = '0; m_com = '0; m_flag = '0; m_oc = '0; m_blk = 0;
    for (int i = 0; i < 3; i++) m_cmp[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a <= 12; a++) rd(4'(a), "R1");

    // R2: latched high byte survives counting
    wr16(4'd0, 16'h12FF, "R3");
    rd(4'd0, "R2");
    ticks(2, "R2");
    rd(4'd1, "R2");
    rd(4'd0, "R2");
    rd(4'd1, "R2");

    // R3: latch shared across registers
    wr(4'd5, 8'hAB, "R3");
    wr(4'd2, 8'h34, "R3");
    rd(4'd2, "R3");
    rd(4'd3, "R3");

    // R4: wrap in mode 0 and in a waveform mode
    wr16(4'd0, 16'hFFFE, "R4");
    ticks(2, "R4");
    rd(4'd0, "R4"); rd(4'd1, "R4");
    wr(4'd8, 8'h02, "R4");
    wr16(4'd0, 16'hFFFF, "R4");
    ticks(2, "R4");
    rd(4'd0, "R4"); rd(4'd1, "R4");

    // R5, R6: clear-on-compare at channel A TOP, flag then W1C
    wr(4'd8, 8'h01, "R5");
    wr16(4'd2, 16'h0005, "R5");
    wr16(4'd0, 16'h0003, "R5");
    ticks(3, "R5");
    rd(4'd0, "R5");
    rd(4'd11, "R6");
    wr(4'd11, 8'h01, "R6");
    rd(4'd11, "R6");

    // R8: write onto a compare value, with and without a tick
    wr(4'd8, 8'h00, "R8");
    wr16(4'd4, 16'h0040, "R8");
    wr16(4'd0, 16'h0040, "R8");
    ticks(1, "R8");
    rd(4'd11, "R8");
    rd(4'd0, "R8");
    wr(4'd1, 8'h00, "R8");
    step(1'b1, 1'b1, 4'd0, 8'h40, 1'b1, "R8");
    ticks(1, "R8");
    rd(4'd0, "R8");
    rd(4'd11, "R8");

    // R7: each action via force in mode 0, and a genuine toggle
    wr(4'd9, 8'b01_00_00, "R7");
    wr(4'd10, 8'h20, "R7"); rd(4'd12, "R7");
    wr(4'd9, 8'b11_00_00, "R7");
    wr(4'd10, 8'h20, "R7"); rd(4'd12, "R7");
    wr(4'd9, 8'b10_00_00, "R7");
    wr(4'd10, 8'h20, "R7"); rd(4'd12, "R7");
    wr(4'd9, 8'b00_00_00, "R7");
    wr(4'd10, 8'h20, "R7"); rd(4'd12, "R7");
    wr(4'd9, 8'b00_01_00, "R7");
    wr16(4'd0, 16'h003F, "R7");
    ticks(2, "R7");
    rd(4'd12, "R7"); rd(4'd11, "R7");

    // R9: force against mode-1 TOP, then in a waveform mode; R10 readback
    wr(4'd11, 8'h07, "R9");
    wr(4'd8, 8'h01, "R9");
    wr16(4'd2, 16'h0050, "R9");
    wr16(4'd0, 16'h0050, "R9");
    wr(4'd9, 8'b00_00_01, "R9");
    wr(4'd10, 8'h80, "R9");
    rd(4'd11, "R9"); rd(4'd0, "R9"); rd(4'd12, "R9");
    wr(4'd8, 8'h03, "R9");
    wr(4'd10, 8'hE0, "R9");
    rd(4'd12, "R9");
    wr(4'd10, 8'hFF, "R10");
    rd(4'd10, "R10");

    // R11: genuine and forced on channel B together, toggle action
    wr(4'd8, 8'h00, "R11");
    wr(4'd9, 8'b00_01_00, "R11");
    wr16(4'd4, 16'h0061, "R11");
    wr16(4'd0, 16'h0060, "R11");
    ticks(1, "R11");
    rd(4'd12, "R11");
    step(1'b1, 1'b1, 4'd10, 8'h40, 1'b1, "R11");
    rd(4'd12, "R11");
    rd(4'd11, "R11");

    // Constrained random mix
    void'($urandom(32'd5150));
    for (int k = 0; k < 4000; k++) begin
      int r;
      logic [3:0] a;
      logic [7:0] d;
      bit tk;
      r  = int'($urandom_range(0, 9));
      a  = 4'($urandom_range(0, 12));
      tk = bit'($urandom_range(0, 1));
      if (a < 4'd8 && a[0]) d = 8'($urandom_range(0, 1));
      else if (a < 4'd8)    d = 8'($urandom_range(0, 31));
      else                  d = 8'($urandom_range(0, 255));
      if (r < 4)      step(1'b1, 1'b0, a, 8'h00, tk, "rand");
      else if (r < 7) step(1'b1, 1'b1, a, d, tk, "rand");
      else            step(1'b0, 1'b0, 4'd0, 8'h00, tk, "rand");
    end
    for (int a = 0; a <= 12; a++) rd(4'(a), "rand");

    finish_run();
  end
endmodule